// File: doc/BRIEF.md
# Serial-Programmed Clock Fan-Out Enable

This block copies one incoming clock onto ten outputs. Each output can be switched on or off through a write-only two-wire serial link. The link works as a standard-mode I2C target that accepts writes only. After its own address it takes up to three data bytes. These bytes fill three 8-bit control registers in a fixed order, and no register address is ever sent. An output whose control bit is 0 stays at a constant low level.

A separate active-high enable input sets whether the outputs are driven. When the enable is low, the drive-enable vector for all ten pads is low, which puts the pads into high impedance. The block drives the serial data line only to pull it low for acknowledge. It samples the serial lines with a faster system clock after a two-stage synchronizer. Each stored enable is moved into the output gate while the incoming clock is low, so a gated output never produces a shortened pulse.

Top module: `clk_fanout_i2c_ctrl`

## Requirements
- R1: After reset every control bit is 1, all ten outputs follow `clk_in`, and `pad_drive` is all ones while `out_en` is 1.
- R2: Only an address byte equal to `{DEV_ADDR, 0}` is acknowledged. A different address, or the correct address with the read bit (bit 0) set to 1, gets no acknowledge and changes no control bit.
- R3: After an acknowledged address, each data byte is acknowledged. The first, second and third data bytes are stored into control registers 0, 1 and 2, in that order.
- R4: A fourth or later data byte in the same transfer is acknowledged and has no effect on any output.
- R5: Every START and every repeated START sends the next data byte to register 0.
- R6: Register 0 bit i enables output i for i = 0..7. Register 1 bit 0 enables output 8 and bit 1 enables output 9. Register 1 bits 2..7 and all of register 2 affect no output.
- R7: An output whose enable is 0 is held at 0. An enabled output equals `clk_in`.
- R8: `pad_drive` is all ones when `out_en` is 1 and all zeros when `out_en` is 0, whatever the control registers hold. `out_en` does not change `clk_out`.
- R9: A new enable value reaches an output only at a falling edge of `clk_in`. While `clk_in` stays high after a write, the outputs keep their previous values.
- R10: `sda_pull` rises only while SCL is low, within four system clocks of the SCL fall that ends the eighth bit of an acknowledged byte. It drops at the next SCL fall, and it is 0 at every other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl | input | 1 | Serial clock line |
| sda | input | 1 | Serial data line as seen on the bus |
| sda_pull | output | 1 | 1 pulls the data line low (acknowledge) |
| clk_in | input | 1 | Clock to be fanned out |
| out_en | input | 1 | Pad drive enable for all outputs, active high |
| clk_out | output | 10 | Gated clock copies |
| pad_drive | output | 10 | Per-pad drive enable, 0 means high impedance |

## Verification
`clk_out` and `pad_drive` are combinational from `clk_in`, the stored enables and `out_en`. They are due in the same instant as their inputs and are compared against the model at every rising system edge. That edge never coincides with a `clk_in` toggle or a bench drive. A register write is due at the first falling `clk_in` edge after the byte ends. The bench parks `clk_in` high during transfers, so the old output state can be checked first and the new one checked after the clock resumes. The acknowledge is due about three system clocks after the SCL fall. It is sampled twelve clocks into the following SCL-high phase, and its release is checked one quarter bit after the next fall.

// File: rtl/clk_fanout_i2c_ctrl.sv
module clk_fanout_i2c_ctrl #(
  parameter int         NOUT     = 10,
  parameter int         NREG     = 3,
  parameter logic [6:0] DEV_ADDR = 7'h52
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            scl,
  input  logic            sda,
  output logic            sda_pull,
  input  logic            clk_in,
  input  logic            out_en,
  output logic [NOUT-1:0] clk_out,
  output logic [NOUT-1:0] pad_drive
);
  localparam int PW = $clog2(NREG + 1);
  localparam int CW = 8 * NREG;

  typedef enum logic [2:0] {IDLE, ADDR, AACK, DATA, DACK} st_t;

  st_t             st;
  logic [2:0]      scl_sr, sda_sr;
  logic [3:0]      bcnt;
  logic [7:0]      sh;
  logic [PW-1:0]   ptr;
  logic [CW-1:0]   ctl;
  logic [NOUT-1:0] en_q;

  wire scl_s = scl_sr[1];
  wire scl_p = scl_sr[2];
  wire sda_s = sda_sr[1];
  wire sda_p = sda_sr[2];
  wire start = scl_s & scl_p & sda_p & ~sda_s;
  wire stop  = scl_s & scl_p & ~sda_p & sda_s;
  wire rise  = scl_s & ~scl_p;
  wire fall  = ~scl_s & scl_p;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_sr <= '1;
      sda_sr <= '1;
    end else begin
      scl_sr <= {scl_sr[1:0], scl};
      sda_sr <= {sda_sr[1:0], sda};
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st       <= IDLE;
      bcnt     <= '0;
      sh       <= '0;
      ptr      <= '0;
      ctl      <= '1;
      sda_pull <= 1'b0;
    end else if (start) begin
      st       <= ADDR;
      bcnt     <= '0;
      ptr      <= '0;
      sda_pull <= 1'b0;
    end else if (stop) begin
      st       <= IDLE;
      sda_pull <= 1'b0;
    end else if (rise && (st == ADDR || st == DATA) && bcnt != 4'd8) begin
      sh   <= {sh[6:0], sda_s};
      bcnt <= bcnt + 4'd1;
    end else if (fall) begin
      case (st)
        ADDR:
          if (bcnt == 4'd8) begin
            if (sh == {DEV_ADDR, 1'b0}) begin
              st       <= AACK;
              sda_pull <= 1'b1;
            end else begin
              st <= IDLE;
            end
          end
        DATA:
          if (bcnt == 4'd8) begin
            for (int k = 0; k < NREG; k++)
              if (ptr == PW'(k)) ctl[8*k +: 8] <= sh;
            if (ptr != PW'(NREG)) ptr <= ptr + 1'b1;
            sda_pull <= 1'b1;
            st       <= DACK;
          end
        AACK, DACK: begin
          sda_pull <= 1'b0;
          st       <= DATA;
          bcnt     <= '0;
        end
        default: ;
      endcase
    end

  always_ff @(negedge clk_in or negedge rst_n)
    if (!rst_n) en_q <= '1;
    else        en_q <= ctl[NOUT-1:0];

  assign clk_out   = {NOUT{clk_in}} & en_q;
  assign pad_drive = {NOUT{out_en}};

  p_ack_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_pull) |-> !scl_s);
  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
    st == IDLE |-> !sda_pull);
  p_ptr_order_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ptr != $past(ptr) |-> (ptr == $past(ptr) + 1'b1 || ptr == '0));
  p_ptr_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(ptr) == PW'(NREG) && !$past(start)) |-> ptr == PW'(NREG));
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == IDLE && $past(st) == IDLE) |-> $stable(ctl));
  p_gate_glitch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(clk_in) && clk_in) |-> $stable(en_q));
endmodule

// File: tb/sim_clk_fanout_i2c_ctrl.sv
module sim_clk_fanout_i2c_ctrl;
  localparam logic [6:0] ADR = 7'h52;
  localparam int Q = 48;

  logic clk = 0, rst_n = 0, clk_in = 0, out_en = 1, ck_run = 1;
  logic scl_m = 1, sda_m = 1;
  logic sda_pull;
  logic [9:0] clk_out, pad_drive;
  wire sda_bus = sda_m & ~sda_pull;

  int checks = 0, errs = 0;
  bit done = 0;
  logic [7:0] mreg [3];
  logic [9:0] m_en;
  int mptr = 0;
  bit mact = 0;

  clk_fanout_i2c_ctrl #(.NOUT(10), .NREG(3), .DEV_ADDR(ADR)) u0 (
    .clk(clk), .rst_n(rst_n), .scl(scl_m), .sda(sda_bus), .sda_pull(sda_pull),
    .clk_in(clk_in), .out_en(out_en), .clk_out(clk_out), .pad_drive(pad_drive));

  always #2 clk = ~clk;

  initial begin
    #1;
    forever begin
      #20;
      if (ck_run || !clk_in) clk_in = ~clk_in;
    end
  end

  always @(negedge clk_in or negedge rst_n)
    if (!rst_n) m_en <= '1;
    else        m_en <= {mreg[1][1:0], mreg[0]};

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk)
    if (rst_n && !done) begin
      chk(clk_out === ({10{clk_in}} & m_en), "R6/R7 per-cycle clk_out", 32'(clk_out), 32'({10{clk_in}} & m_en));
      chk(pad_drive === {10{out_en}}, "R8 per-cycle pad_drive", 32'(pad_drive), 32'({10{out_en}}));
    end

  task automatic i2c_start();
    sda_m = 1; #Q; scl_m = 1; #Q; sda_m = 0; #Q; scl_m = 0; #Q;
    mptr = 0; mact = 0;
  endtask

  task automatic i2c_stop();
    sda_m = 0; #Q; scl_m = 1; #Q; sda_m = 1; #Q;
    mact = 0;
  endtask

  task automatic send(input logic [7:0] b, input bit is_addr);
    bit exp_ack, ack;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #Q; scl_m = 1; #Q;
      chk(sda_pull == 1'b0, "R10 no drive during data bit", 32'(sda_pull), 0);
      #Q; scl_m = 0; #Q;
    end
    exp_ack = is_addr ? (b[7:1] == ADR && !b[0]) : mact;
    sda_m = 1; #Q; scl_m = 1; #Q;
    ack = !sda_bus;
    chk(ack == exp_ack, is_addr ? "R2 address acknowledge" : "R3/R4 data acknowledge", 32'(ack), 32'(exp_ack));
    #Q; scl_m = 0; #Q;
    chk(sda_pull == 1'b0, "R10 acknowledge released", 32'(sda_pull), 0);
    if (is_addr) mact = exp_ack;
    else if (mact && mptr < 3) begin
      mreg[mptr] = b;
      mptr++;
    end
  endtask

  task automatic park();
    ck_run = 0;
    wait (clk_in == 1'b1);
    @(negedge clk);
  endtask

  task automatic resume_and_settle();
    ck_run = 1;
    @(negedge clk_in);
    @(posedge clk_in);
    @(negedge clk);
  endtask

  task automatic wr3(input logic [7:0] a, input logic [7:0] b, input logic [7:0] c);
    i2c_start(); send({ADR, 1'b0}, 1); send(a, 0); send(b, 0); send(c, 0); i2c_stop();
  endtask

  initial begin
    for (int k = 0; k < 3; k++) mreg[k] = 8'hFF;
    repeat (10) @(negedge clk);
    rst_n = 1;
    @(posedge clk_in); @(negedge clk);
    chk(clk_out === 10'h3FF, "R1 reset outputs enabled", 32'(clk_out), 32'h3FF);
    chk(pad_drive === 10'h3FF, "R1 reset pad drive", 32'(pad_drive), 32'h3FF);
    @(negedge clk_in); @(negedge clk);
    chk(clk_out === 10'h000, "R1 outputs follow low clock", 32'(clk_out), 0);

    // R2: wrong address and read direction are ignored
    park();
    i2c_start(); send({ADR ^ 7'h01, 1'b0}, 1); i2c_stop();
    i2c_start(); send({ADR, 1'b1}, 1); i2c_stop();
    resume_and_settle();
    chk(clk_out === 10'h3FF, "R2 ignored transfers leave outputs", 32'(clk_out), 32'h3FF);

    // R3, R6, R7, R9: ordered fill, mapping, delayed effect
    park();
    wr3(8'hF0, 8'h01, 8'h00);
    repeat (5) @(negedge clk);
    chk(clk_out === 10'h3FF, "R9 no change while clk_in high", 32'(clk_out), 32'h3FF);
    resume_and_settle();
    chk(clk_out === 10'h1F0, "R3 ordered fill applied", 32'(clk_out), 32'h1F0);
    @(negedge clk_in); @(negedge clk);
    chk(clk_out === 10'h000, "R7 disabled outputs low", 32'(clk_out), 0);

    // R4: extra byte discarded
    park();
    i2c_start(); send({ADR, 1'b0}, 1);
    send(8'hFF, 0); send(8'hFF, 0); send(8'hFF, 0); send(8'h00, 0);
    i2c_stop();
    resume_and_settle();
    chk(clk_out === 10'h3FF, "R4 fourth byte discarded", 32'(clk_out), 32'h3FF);

    // R5: repeated START returns to register 0
    park();
    i2c_start(); send({ADR, 1'b0}, 1); send(8'h0F, 0);
    i2c_start(); send({ADR, 1'b0}, 1); send(8'hAA, 0);
    i2c_stop();
    resume_and_settle();
    chk(clk_out === 10'h3AA, "R5 repeated start rewrites register 0", 32'(clk_out), 32'h3AA);

    // R6: unused bits have no effect
    park();
    wr3(8'hFF, 8'h03, 8'h00);
    resume_and_settle();
    chk(clk_out === 10'h3FF, "R6 unused bits no effect", 32'(clk_out), 32'h3FF);
    park();
    wr3(8'hFF, 8'hFC, 8'hFF);
    resume_and_settle();
    chk(clk_out === 10'h0FF, "R6 outputs 8 and 9 from register 1", 32'(clk_out), 32'h0FF);

    // R8: pad drive follows out_en only
    out_en = 0;
    repeat (3) @(negedge clk);
    chk(pad_drive === 10'h000, "R8 pads released", 32'(pad_drive), 0);
    wait (clk_in == 1'b1); @(negedge clk);
    chk(clk_out === 10'h0FF, "R8 clk_out unaffected", 32'(clk_out), 32'h0FF);
    out_en = 1;
    repeat (3) @(negedge clk);
    chk(pad_drive === 10'h3FF, "R8 pads driven", 32'(pad_drive), 32'h3FF);

    repeat (20) @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  end

  initial begin
    #(150000 * 4);
    if (!done) begin
      done = 1;
      checks++; errs++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errs);
      $finish;
    end
  end
endmodule